// File: doc/BRIEF.md
# Five-Level Phase-Shifted PWM Leg Modulator

This block produces the switch commands for one phase leg of a five-level active neutral-point-clamped converter. It takes a signed fixed-point phase voltage reference, scaled so that one unit equals the flying-capacitor voltage and the usable span runs from -2 to +2. The reference's sign drives the high-voltage switch pair, which therefore changes state only at the fundamental frequency. The reference is then folded into a unipolar modulation value between 0 and 1 and compared against two triangular carriers, half a carrier period apart, to drive the two fast switch pairs.

A signed trim input moves the two compare thresholds in opposite directions. The output level stays the same while the time spent in the redundant switching states changes, and this is what regulates the flying-capacitor voltage. A single up/down counter with a programmable half period produces both carriers. All new inputs are captured only at the carrier valley, so the thresholds never change in the middle of a period.

Top module: `pspwm5_leg`

## Requirements
- R1: While reset is active, and right after it, all four switch commands are 0 and all four complements are 1.
- R2: Each bit of `gateOutN` is always the inverse of the matching bit of `gateOut`.
- R3: Bits 2 and 3 of `gateOut` are always equal. Both are 1 when the reference captured at the last valley was at or above zero, and 0 when it was negative.
- R4: The counter counts up from 0 to the half period H and then back down to 0, so one carrier period lasts 2*H clocks. Carrier A equals the count and carrier B equals H minus the count.
- R5: The modulation value m, in units of 2^-FRAC, is ref/2 for a reference at or above zero and (ref+2)/2 for a negative one, limited to the range 0..1. The base threshold is floor(m*H).
- R6: `gateOut[0]` is 1 exactly when carrier A is below threshold A. `gateOut[1]` is 1 exactly when carrier B is below threshold B. With no trim, both thresholds equal the base threshold.
- R7: A positive trim t makes threshold A equal base-t and threshold B equal base+t, so the first fast switch conducts less and the second conducts more. A negative trim does the reverse. When neither threshold saturates, the combined on-time of the two fast switches over a period does not change.
- R8: Each trimmed threshold is limited to the range 0..H. A threshold of 0 gives no pulse at all, and a threshold of H keeps the switch on except at the carrier peak.
- R9: The reference, trim and half period are captured only at the valley, when the count is 0. A change applied at any other point has no effect on the outputs until the next valley.
- R10: A half-period input of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| periodIn | input | CW | Carrier half period in clocks (0 is treated as 1) |
| refIn | input | RW | Signed phase voltage reference, FRAC fraction bits |
| trimIn | input | CW | Signed threshold trim in clocks, used for flying-capacitor balance |
| gateOut | output | 4 | Switch commands: bit0 fast pair 1, bit1 fast pair 2, bits 2 and 3 high-voltage pairs |
| gateOutN | output | 4 | Complementary switch commands |

## Verification
The outputs are decoded directly from registered state, with no further register stage. A counter step therefore shows at the ports in the same clock period as the rising edge that causes it. An input change is captured on the first rising edge at which the count is 0, and it appears at the ports during the clock period after that edge. The bench keeps a behavioural model that advances on every rising edge and compares it with the ports on every falling edge, so each output is checked exactly one half period after the edge that makes it due. The duty-count checks begin at a valley only after the inputs have been held for several periods, so they see only settled thresholds. The mid-period test changes the reference a few counts after a valley and checks that nothing moves until the next valley.

// File: rtl/pspwm5_pkg.sv
package pspwm5_pkg;
  // Strobes from the counter control to the modulation datapath
  typedef struct packed {
    logic latch;   // carrier valley: capture new reference, trim and period
  } pwmStrobe_t;
endpackage

// File: rtl/pspwm5_ctrl.sv
module pspwm5_ctrl
  import pspwm5_pkg::*;
#(
  parameter int CW       = 12,
  parameter int DEF_HALF = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [CW-1:0] periodIn,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] pCur,
  output logic [CW-1:0] nextP,
  output pwmStrobe_t    strb
);
  logic          up;
  logic [CW-1:0] effP;

  always_comb begin
    nextP      = (periodIn == '0) ? CW'(1) : periodIn;   // R10
    strb.latch = (cnt == '0);
    effP       = strb.latch ? nextP : pCur;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt  <= '0;
      up   <= 1'b1;
      pCur <= CW'(DEF_HALF);
    end else begin
      if (strb.latch) pCur <= nextP;
      if (up) begin
        cnt <= cnt + 1'b1;
        if (cnt + 1'b1 >= effP) up <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
        if (cnt <= CW'(1)) up <= 1'b1;
      end
    end
  end

  // R4: counter stays within the triangle and steps by one each clock
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= pCur);
  assert_cnt_rise_R4: assert property (@(posedge clk) disable iff (!rstN)
    up |=> cnt == $past(cnt) + 1'b1);
  assert_cnt_fall_R4: assert property (@(posedge clk) disable iff (!rstN)
    !up |=> cnt == $past(cnt) - 1'b1);
endmodule

// File: rtl/pspwm5_dp.sv
module pspwm5_dp
  import pspwm5_pkg::*;
#(
  parameter int CW   = 12,
  parameter int RW   = 16,
  parameter int FRAC = 13
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pwmStrobe_t           strb,
  input  logic [CW-1:0]        cnt,
  input  logic [CW-1:0]        pCur,
  input  logic [CW-1:0]        nextP,
  input  logic signed [RW-1:0] refIn,
  input  logic signed [CW-1:0] trimIn,
  output logic                 s1,
  output logic                 s2,
  output logic                 s3
);
  localparam int EW  = RW + 2;
  localparam int PW  = FRAC + CW + 1;
  localparam int TW  = CW + 2;
  localparam int ONE = 1 << FRAC;
  localparam int TWO = 1 << (FRAC + 1);

  logic                 isPos;
  logic signed [EW-1:0] refExt, halfRef;
  logic [FRAC:0]        mScaled;
  logic [PW-1:0]        prod;
  logic [CW:0]          base;
  logic signed [TW-1:0] baseS, trimS, pS, aRaw, bRaw;
  logic [CW-1:0]        thrANext, thrBNext;
  logic [CW-1:0]        thrA, thrB, carB;

  function automatic logic [CW-1:0] satThr(input logic signed [TW-1:0] v,
                                           input logic signed [TW-1:0] lim);
    if (v < 0)        return '0;
    else if (v > lim) return CW'(lim);
    else              return CW'(v);
  endfunction

  // R5: fold the bipolar reference into a unipolar modulation value
  always_comb begin
    isPos   = !refIn[RW-1];
    refExt  = EW'(refIn);
    halfRef = isPos ? (refExt >>> 1) : ((refExt + EW'(TWO)) >>> 1);
    if (halfRef < 0)             mScaled = '0;
    else if (halfRef > EW'(ONE)) mScaled = (FRAC+1)'(ONE);
    else                         mScaled = (FRAC+1)'(halfRef);
    prod = PW'(mScaled) * PW'(nextP);
    base = prod[PW-1:FRAC];
  end

  // R7/R8: opposite trim on the two thresholds, clamped to the carrier span
  always_comb begin
    baseS    = $signed(TW'(base));
    trimS    = TW'(trimIn);
    pS       = $signed(TW'(nextP));
    aRaw     = baseS - trimS;
    bRaw     = baseS + trimS;
    thrANext = satThr(aRaw, pS);
    thrBNext = satThr(bRaw, pS);
  end

  // R9: capture only at the valley
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      thrA <= '0;
      thrB <= '0;
      s3   <= 1'b0;
    end else if (strb.latch) begin
      thrA <= thrANext;
      thrB <= thrBNext;
      s3   <= isPos;
    end
  end

  // R6: compare against the two mirrored carriers
  always_comb begin
    carB = pCur - cnt;
    s1   = (cnt < thrA);
    s2   = (carB < thrB);
  end

  assert_thr_limit_R8: assert property (@(posedge clk) disable iff (!rstN)
    (thrA <= pCur) && (thrB <= pCur));
  assert_thr_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latch |=> $stable(thrA) && $stable(thrB));
  assert_hv_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latch |=> $stable(s3));
endmodule

// File: rtl/pspwm5_leg.sv
module pspwm5_leg
  import pspwm5_pkg::*;
#(
  parameter int CW       = 12,
  parameter int RW       = 16,
  parameter int FRAC     = 13,
  parameter int DEF_HALF = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [CW-1:0]        periodIn,
  input  logic signed [RW-1:0] refIn,
  input  logic signed [CW-1:0] trimIn,
  output logic [3:0]           gateOut,
  output logic [3:0]           gateOutN
);
  pwmStrobe_t    strb;
  logic [CW-1:0] cnt, pCur, nextP;
  logic          s1, s2, s3;

  pspwm5_ctrl #(.CW(CW), .DEF_HALF(DEF_HALF)) u_ctrl (
    .clk(clk), .rstN(rstN), .periodIn(periodIn),
    .cnt(cnt), .pCur(pCur), .nextP(nextP), .strb(strb)
  );

  pspwm5_dp #(.CW(CW), .RW(RW), .FRAC(FRAC)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cnt(cnt), .pCur(pCur),
    .nextP(nextP), .refIn(refIn), .trimIn(trimIn),
    .s1(s1), .s2(s2), .s3(s3)
  );

  // R3: both high-voltage pairs share one command; R2: complements
  always_comb begin
    gateOut  = {s3, s3, s2, s1};
    gateOutN = ~gateOut;
  end

  assert_hv_pair_R3: assert property (@(posedge clk) disable iff (!rstN)
    gateOut[3] == gateOut[2]);
endmodule

// File: tb/test_pspwm5_leg.sv
module test_pspwm5_leg;
  localparam int CW = 12, RW = 16, FRAC = 13, DEF_HALF = 8;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic [CW-1:0]        periodIn = 12'd8;
  logic signed [RW-1:0] refIn = '0;
  logic signed [CW-1:0] trimIn = '0;
  logic [3:0]           gateOut, gateOutN;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  pspwm5_leg #(.CW(CW), .RW(RW), .FRAC(FRAC), .DEF_HALF(DEF_HALF)) i_pspwm5_leg (
    .clk(clk), .rstN(rstN), .periodIn(periodIn), .refIn(refIn),
    .trimIn(trimIn), .gateOut(gateOut), .gateOutN(gateOutN)
  );

  always #5 clk = ~clk;

  // Behavioural reference model
  int mC, mP, mThrA, mThrB;
  bit mUp, mS3;

  function automatic int clampI(int v, int lo, int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mC = 0; mUp = 1; mP = DEF_HALF; mThrA = 0; mThrB = 0; mS3 = 0;
    end else begin
      if (mC == 0) begin
        int r, m, b, t;
        mP = (periodIn == 0) ? 1 : int'(periodIn);
        r  = int'(refIn);
        t  = int'(trimIn);
        m  = (r >= 0) ? r / 2 : (r + (1 << (FRAC + 1))) / 2;
        m  = clampI(m, 0, 1 << FRAC);
        b  = (m * mP) >> FRAC;
        mThrA = clampI(b - t, 0, mP);
        mThrB = clampI(b + t, 0, mP);
        mS3   = (r >= 0);
      end
      if (mUp) begin
        mC++;
        if (mC >= mP) mUp = 0;
      end else begin
        mC--;
        if (mC == 0) mUp = 1;
      end
    end
  end

  // Per-cycle comparison (R2 R3 R6)
  always @(negedge clk) begin
    if (rstN && !done) begin
      logic [3:0] exp;
      exp[0] = (mC < mThrA);
      exp[1] = ((mP - mC) < mThrB);
      exp[2] = mS3;
      exp[3] = mS3;
      total++;
      if (gateOut !== exp || gateOutN !== ~exp) begin
        bad++;
        $display("FAIL R2 R3 R6 cycle %0d: gate=%b n=%b expected gate=%b n=%b",
                 cyc, gateOut, gateOutN, exp, ~exp);
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(string tag, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  // Count the on-cycles of each fast switch over one period, starting at a valley
  task automatic countPeriod(input int half, output int n1, output int n2);
    n1 = 0; n2 = 0;
    do @(negedge clk); while (mC != 0);
    for (int i = 0; i < 2 * half; i++) begin
      n1 += gateOut[0];
      n2 += gateOut[1];
      @(negedge clk);
    end
  endtask

  task automatic runCase(string tag, int rv, int tv, int half, int e1, int e2, int e3);
    int n1, n2;
    refIn  = RW'(rv);
    trimIn = CW'(tv);
    periodIn = CW'(half);
    settle(6 * ((half == 0) ? 1 : half) + 4);
    countPeriod((half == 0) ? 1 : half, n1, n2);
    check({tag, " S1 count"}, n1, e1);
    check({tag, " S2 count"}, n2, e2);
    check({tag, " S3"}, gateOut[2], e3);
  endtask

  initial begin
    int n1a, n2a, n1b, n2b;
    // R1: reset state
    #2;
    check("R1 gateOut in reset", gateOut, 0);
    check("R1 gateOutN in reset", gateOutN, 15);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1 gateOut after reset", gateOut, 0);

    // R5 R6: H=8, ref=+1.0 -> m=0.5, base 4 -> 7 of 16 cycles each
    runCase("R5 R6 ref+1", 8192, 0, 8, 7, 7, 1);
    // R3 R5: ref=-1.0 -> m=0.5, HV pair off
    runCase("R3 R5 ref-1", -8192, 0, 8, 7, 7, 0);
    // R5: ref=+1.5 -> base 6
    runCase("R5 ref+1.5", 12288, 0, 8, 11, 11, 1);
    // R5: ref=-2.0 -> m=0
    runCase("R5 ref-2", -16384, 0, 8, 0, 0, 0);
    // R5 R8: ref above range clamps to m=1
    runCase("R5 R8 ref clamp", 20000, 0, 8, 15, 15, 1);
    // R7: positive trim shifts on-time from S1 to S2
    runCase("R7 trim+2", 8192, 2, 8, 3, 11, 1);
    countPeriod(8, n1a, n2a);
    check("R7 combined on-time", n1a + n2a, 14);
    // R7: negative trim the other way
    runCase("R7 trim-2", 8192, -2, 8, 11, 3, 1);
    // R8: large trims saturate
    runCase("R8 trim+20", 8192, 20, 8, 0, 15, 1);
    runCase("R8 trim-20", 8192, -20, 8, 15, 0, 1);
    // R4: other period, H=5, ref=+1.0 -> base 2 -> 3 of 10
    runCase("R4 half5", 8192, 0, 5, 3, 3, 1);
    // R10: period 0 acts as 1, ref=+2.0 -> thr 1 -> 1 of 2
    runCase("R10 half0", 16384, 0, 0, 1, 1, 1);

    // R9: mid-period change is ignored until the next valley
    runCase("R9 setup", 8192, 0, 8, 7, 7, 1);
    do @(negedge clk); while (mC != 3);
    refIn  = RW'(-16384);
    trimIn = CW'(5);
    @(negedge clk);
    check("R9 HV held mid-period", gateOut[2], 1);
    countPeriod(8, n1b, n2b);   // begins at the valley, still old values until latched
    check("R9 HV after valley", gateOut[2], 0);
    check("R9 S1 after valley", gateOut[0], 0);

    settle(4);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule